// File: doc/BRIEF.md
# USB full-speed transmit line driver

This block turns a stream of parallel bytes into the line signals of a full-speed USB transmitter. It runs from a 48 MHz system clock and derives a one-cycle-in-four bit enable, which gives the 12 Mbit/s bit time. A higher layer presents bytes with a valid/ready handshake; each byte is sent least significant bit first. A zero bit is inserted after every six consecutive ones. The bits are NRZI-encoded, and each packet is closed with an end-of-packet pattern before the driver lets go of the bus.

The line state (J, K or single-ended zero) is turned into the `txdn`/`txdp` pin pair under one of two encodings, picked by a static mode input, so that the block can sit in front of transceivers that take either code map. The packet header (SYNC and PID) is ordinary payload to this block and comes from the layer above.

Top module: `usb_fs_tx`

## Requirements
- R1: The line state and the output enable change only on the clock edge that ends a bit time. A bit time is CLK_PER_BIT = 4 system clocks, counted from reset release, so updates appear on clock edges 4, 8, 12 and so on.
- R2: After reset, `line_oe` is 0, the pins carry the J code `{txdn,txdp}` = 01 in both modes, and `tx_ready` is 0.
- R3: `tx_ready` is high for exactly one clock per accepted byte, only while `tx_valid` is high and only at a bit-time boundary. The first byte of a packet is taken at the first boundary seen in idle with `tx_valid` high. One bit time of J with `line_oe` high follows before the first data bit.
- R4: Data bits go out least significant bit first and are NRZI-coded starting from J. A 0 bit toggles the line between J and K, and a 1 bit holds it.
- R5: After six consecutive transmitted 1 bits, one extra 0 bit (a line toggle) is sent before anything else, and this resets the run. This also applies when the sixth 1 is the last bit of the packet, in which case the stuffed bit comes before the end-of-packet.
- R6: When a byte's last bit goes out while `tx_valid` is low, the block sends two bit times of single-ended zero and then one bit time of J. It then drops `line_oe` and returns to idle.
- R7: With `mode_sel` = 0, `{txdn,txdp}` is 00 for K, 01 for J and 10 for single-ended zero.
- R8: With `mode_sel` = 1, `{txdn,txdp}` is 10 for K, 01 for J and 00 for single-ended zero, and 11 is never driven.
- R9: A byte offered with `tx_valid` high by the end of the previous byte's last bit is taken on that same boundary. Its first bit follows in the next bit time with no gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 48 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 1 | Pin code map select (0 or 1, see R7/R8) |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Byte on `tx_data` is valid; low at a byte end closes the packet |
| tx_ready | output | 1 | One-clock pulse when the byte on `tx_data` is taken |
| txdp | output | 1 | Plus line drive code bit |
| txdn | output | 1 | Minus line drive code bit |
| line_oe | output | 1 | High while the block drives the bus |

## Verification
The bench sweeps every single-byte value in both pin modes, plus multi-byte packets of long one-runs, and decodes the pins back into line states at each bit boundary. It compares them with a stream it builds on its own. Runs of ones that reach six exactly at a byte end or at the packet end are the sharpest cases. A design that counts the run wrongly, or forgets the stuffed bit before the end-of-packet, produces a stream one bit short or with a missing toggle, and later bits flip polarity. Back-to-back bytes catch a design that reloads a bit time late and leaves a gap. The mode-1 sweep watches for the forbidden 11 pair, and a check on pin changes off the bit boundary catches glitches between bit times.

// File: rtl/usb_fs_tx_pkg.sv
package usb_fs_tx_pkg;

  typedef enum logic [1:0] {
    LS_J   = 2'd0,
    LS_K   = 2'd1,
    LS_SE0 = 2'd2
  } line_t;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_DATA = 3'd1,
    ST_SE0A = 3'd2,
    ST_SE0B = 3'd3,
    ST_JEND = 3'd4
  } tx_st_t;

  // NRZI: a one keeps the level, a zero flips between J and K
  function automatic line_t nrzi_step(input line_t cur, input logic b);
    if (b) return cur;
    return (cur == LS_K) ? LS_J : LS_K;
  endfunction

  // Pin pair {dn, dp} for a line state under the selected code map
  function automatic logic [1:0] pin_code(input logic mode, input line_t ls);
    case (ls)
      LS_J:    return 2'b01;
      LS_K:    return mode ? 2'b10 : 2'b00;
      default: return mode ? 2'b00 : 2'b10;
    endcase
  endfunction

endpackage

// File: rtl/usb_fs_tx_bitclk.sv
module usb_fs_tx_bitclk #(
  parameter int CLK_PER_BIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic bit_en
);
  localparam int CW = (CLK_PER_BIT > 2) ? $clog2(CLK_PER_BIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_PER_BIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  assign bit_en = (cnt_q == LAST);

  // R1
  en_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en |=> !bit_en);

endmodule

// File: rtl/usb_fs_tx_ser.sv
module usb_fs_tx_ser
  import usb_fs_tx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int STUFF_LIMIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output line_t             line_q,
  output logic              oe_q
);
  localparam int IW = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam int SW = $clog2(STUFF_LIMIT + 1);
  localparam logic [IW-1:0] IDX_LAST = IW'(DATA_W - 1);
  localparam logic [SW-1:0] RUN_MAX  = SW'(STUFF_LIMIT);

  tx_st_t            st;
  logic [DATA_W-1:0] sh;
  logic [IW-1:0]     idx;
  logic              have;
  logic [SW-1:0]     ones;

  // named events
  logic in_data, start_ev, stuff_ev, emit_ev, last_ev, load_ev, end_ev;

  always_comb begin
    in_data  = (st == ST_DATA);
    start_ev = bit_en && (st == ST_IDLE) && tx_valid;
    stuff_ev = bit_en && in_data && (ones == RUN_MAX);
    emit_ev  = bit_en && in_data && !stuff_ev && have;
    last_ev  = emit_ev && (idx == IDX_LAST);
    load_ev  = start_ev || (last_ev && tx_valid);
    end_ev   = bit_en && in_data && !stuff_ev && !have;
  end

  assign tx_ready = load_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      sh     <= '0;
      idx    <= '0;
      have   <= 1'b0;
      ones   <= '0;
      line_q <= LS_J;
      oe_q   <= 1'b0;
    end else begin
      if (start_ev) begin
        st     <= ST_DATA;
        oe_q   <= 1'b1;
        line_q <= LS_J;
        ones   <= '0;
      end
      if (stuff_ev) begin
        line_q <= nrzi_step(line_q, 1'b0);
        ones   <= '0;
      end
      if (emit_ev) begin
        line_q <= nrzi_step(line_q, sh[0]);
        ones   <= sh[0] ? ones + 1'b1 : '0;
        sh     <= sh >> 1;
        idx    <= idx + 1'b1;
        if (last_ev) have <= 1'b0;
      end
      if (load_ev) begin
        sh   <= tx_data;
        idx  <= '0;
        have <= 1'b1;
      end
      if (end_ev) begin
        st     <= ST_SE0A;
        line_q <= LS_SE0;
      end
      if (bit_en) begin
        case (st)
          ST_SE0A: st <= ST_SE0B;
          ST_SE0B: begin st <= ST_JEND; line_q <= LS_J; end
          ST_JEND: begin st <= ST_IDLE; oe_q <= 1'b0; end
          default: ;
        endcase
      end
    end
  end

  // R5
  ones_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ones <= RUN_MAX);

  // R3
  ready_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (tx_valid && bit_en));

  // R1
  line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bit_en) |-> ($stable(line_q) && $stable(oe_q)));

  // R6
  oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_q) |-> ($past(line_q) == LS_J));

  // R6
  se0_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SE0B) |-> (line_q == LS_SE0));

endmodule

// File: rtl/usb_fs_tx_enc.sv
module usb_fs_tx_enc
  import usb_fs_tx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  mode_sel,
  input  line_t line_q,
  output logic  txdp,
  output logic  txdn
);
  logic [1:0] pair;

  always_comb pair = pin_code(mode_sel, line_q);

  assign txdn = pair[1];
  assign txdp = pair[0];

  // R8
  no_illegal_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel |-> !(txdn && txdp));

endmodule

// File: rtl/usb_fs_tx.sv
module usb_fs_tx
  import usb_fs_tx_pkg::*;
#(
  parameter int CLK_PER_BIT = 4,
  parameter int DATA_W      = 8,
  parameter int STUFF_LIMIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_sel,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              txdp,
  output logic              txdn,
  output logic              line_oe
);
  logic  bit_en;
  line_t line_q;

  usb_fs_tx_bitclk #(.CLK_PER_BIT(CLK_PER_BIT)) bitclk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .bit_en (bit_en)
  );

  usb_fs_tx_ser #(.DATA_W(DATA_W), .STUFF_LIMIT(STUFF_LIMIT)) ser_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .tx_data  (tx_data),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .line_q   (line_q),
    .oe_q     (line_oe)
  );

  usb_fs_tx_enc enc_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_sel (mode_sel),
    .line_q   (line_q),
    .txdp     (txdp),
    .txdn     (txdn)
  );

endmodule

// File: tb/usb_fs_tx_tb_top.sv
`timescale 1ns/1ps
module usb_fs_tx_tb_top;
  localparam int SYM_J = 0, SYM_K = 1, SYM_SE0 = 2, SYM_ILL = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_sel = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0;
  logic       tx_ready, txdp, txdn, line_oe;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  usb_fs_tx dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .txdp(txdp), .txdn(txdn),
    .line_oe(line_oe)
  );

  // bit-time phase reference: 4 clocks per bit, counted from reset release
  int ph;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= 0;
    else        ph <= (ph == 3) ? 0 : ph + 1;
  end

  function automatic int dec(input logic m, input logic dn, input logic dp);
    if (!m) return dp ? (dn ? SYM_SE0 : SYM_J) : (dn ? SYM_SE0 : SYM_K);
    case ({dn, dp})
      2'b00:   return SYM_SE0;
      2'b01:   return SYM_J;
      2'b10:   return SYM_K;
      default: return SYM_ILL;
    endcase
  endfunction

  // monitor
  int  got[$];
  int  pkt_done = 0;
  int  rdy_cnt = 0;
  int  rdy_wo_valid = 0;
  int  offgrid = 0;
  int  illegal = 0;
  bit  collecting = 1'b0;
  logic [2:0] prev_pins = 3'b001;

  always @(negedge clk) begin
    if (rst_n) begin
      if ({line_oe, txdn, txdp} != prev_pins && ph != 0) offgrid++;
      prev_pins = {line_oe, txdn, txdp};
      if (mode_sel && txdn && txdp) illegal++;
      if (tx_ready) begin
        rdy_cnt++;
        if (!tx_valid) rdy_wo_valid++;
      end
      if (ph == 0) begin
        if (line_oe) begin
          got.push_back(dec(mode_sel, txdn, txdp));
          collecting = 1'b1;
        end else if (collecting) begin
          collecting = 1'b0;
          pkt_done++;
        end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  // independent model of the line stream for a packet
  int exp_s[$];
  task automatic build(input logic [7:0] b[$]);
    int lvl, run;
    exp_s.delete();
    lvl = SYM_J;
    run = 0;
    exp_s.push_back(SYM_J);
    foreach (b[i]) begin
      for (int k = 0; k < 8; k++) begin
        if (run == 6) begin
          lvl = (lvl == SYM_J) ? SYM_K : SYM_J;
          exp_s.push_back(lvl);
          run = 0;
        end
        if (b[i][k]) run++;
        else begin
          run = 0;
          lvl = (lvl == SYM_J) ? SYM_K : SYM_J;
        end
        exp_s.push_back(lvl);
      end
    end
    if (run == 6) begin
      lvl = (lvl == SYM_J) ? SYM_K : SYM_J;
      exp_s.push_back(lvl);
    end
    exp_s.push_back(SYM_SE0);
    exp_s.push_back(SYM_SE0);
    exp_s.push_back(SYM_J);
  endtask

  task automatic send_pkt(input logic [7:0] b[$], input string tag);
    int g0, r0, d0, n, bad, act_v, exp_v;
    build(b);
    g0 = got.size();
    r0 = rdy_cnt;
    d0 = pkt_done;
    foreach (b[i]) begin
      tx_data  = b[i];
      tx_valid = 1'b1;
      do @(negedge clk); while (!tx_ready);
      @(posedge clk);
      #1;
    end
    tx_valid = 1'b0;
    n = 0;
    while (pkt_done == d0 && n < 400) begin
      @(posedge clk);
      n++;
    end
    chk({tag, " R6 packet closes"}, pkt_done - d0, 1);
    chk({tag, " R3 one ready per byte"}, rdy_cnt - r0, b.size());
    chk({tag, " R4 R5 stream length"}, got.size() - g0, exp_s.size());
    bad = -1;
    act_v = 0;
    exp_v = 0;
    for (int i = 0; i < exp_s.size(); i++) begin
      if (bad < 0 && g0 + i < got.size() && got[g0 + i] != exp_s[i]) begin
        bad = i;
        act_v = got[g0 + i];
        exp_v = exp_s[i];
      end
    end
    chk({tag, " R4 R5 R9 stream symbol"}, act_v, exp_v);
    if (got.size() - g0 >= 3)
      chk({tag, " R6 tail SE0 SE0 J"}, got[got.size()-3]*16 + got[got.size()-2]*4 + got[got.size()-1],
          SYM_SE0*16 + SYM_SE0*4 + SYM_J);
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    logic [7:0] pk[$];
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R2
    chk("R2 idle oe", line_oe, 0);
    chk("R2 idle J pins mode0", {txdn, txdp}, 2'b01);
    chk("R2 idle ready", tx_ready, 0);
    mode_sel = 1'b1;
    @(negedge clk);
    chk("R2 idle J pins mode1", {txdn, txdp}, 2'b01);

    for (int m = 0; m < 2; m++) begin
      mode_sel = m[0];
      repeat (8) @(posedge clk);
      #1;
      for (int v = 0; v < 256; v++) begin
        pk = '{8'(v)};
        send_pkt(pk, (m == 0) ? "R7 byte sweep" : "R8 byte sweep");
      end
      pk = '{8'hFF, 8'hFF, 8'hFF};  send_pkt(pk, "R5 R9 ones run");
      pk = '{8'h3F};                send_pkt(pk, "R5 six at end");
      pk = '{8'hFC, 8'h0F};         send_pkt(pk, "R5 R9 run across bytes");
      pk = '{8'h00, 8'h00};         send_pkt(pk, "R4 R9 zeros");
      pk = '{8'h80, 8'h01, 8'hC3};  send_pkt(pk, "R4 R9 mixed");
    end

    chk("R1 pins change only on bit boundary", offgrid, 0);
    chk("R8 no 11 pair in mode1", illegal, 0);
    chk("R3 ready only with valid", rdy_wo_valid, 0);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule